// File: doc/BRIEF.md
# Quadrature Encoder Edge Counter

This block counts transitions on two external pins, A and B, that arrive asynchronously to a fast system clock. Each pin is resynchronised and turned into rise and fall events. The events are then decoded into up or down steps for a count register that runs between zero and a programmable ceiling.

In pulse mode only pin A counts, always upward, on the rising edge, the falling edge or both edges, as the edge select chooses. In quadrature mode both pins count. Each edge that the edge select admits steps the count up or down, depending on which pin moved and on the level of the other pin. With both edges admitted the result is full four-times quadrature decoding. With a single polarity admitted, only that half of the transitions counts.

A direction flag shows whether the most recent step was downward. The ceiling is loaded through a one-cycle strobe. A loaded value above the build-time maximum is clamped to that maximum, and every load clears the count.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count is 0, the direction flag is 0, and the ceiling equals the parameter MAX_CEIL.
- R2: With `quad_mode`=0 the count steps up by one on each admitted edge of A and never steps down. The `edge_sel` encoding is 0 = rising only, 1 = falling only, 2 or 3 = both.
- R3: With `quad_mode`=0, transitions of B have no effect on the count or on the direction flag.
- R4: With `quad_mode`=1 and `edge_sel`=0, only rising edges count. A rising on A counts down when B is 1 and up when B is 0. A rising on B counts up when A is 1 and down when A is 0.
- R5: With `quad_mode`=1 and `edge_sel`=1, only falling edges count. A falling on A counts up when B is 1 and down when B is 0. A falling on B counts down when A is 1 and up when A is 0.
- R6: With `quad_mode`=1 and `edge_sel`=2 or 3, every transition counts. The state order (A,B) = 00, 10, 11, 01 counts up, and the reverse order counts down.
- R7: In quadrature mode, when A and B change in the same synchronised cycle, no step occurs.
- R8: A step up from a count equal to the ceiling gives 0, and the count never exceeds the ceiling.
- R9: A step down from a count of 0 gives the ceiling value.
- R10: A `ceil_load` pulse sets the ceiling to `ceil_value`, clamped to MAX_CEIL, and clears the count on the same clock edge. A load takes priority over a step in that cycle.
- R11: `dir_down` becomes 1 after a down step and 0 after an up step, and holds its value when no step occurs.
- R12: A pin change set up before clock edge 1 reaches the count at clock edge 3: two synchroniser stages, then the count register. The count changes only on a decoded step or a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Asynchronous pin A |
| in_b | input | 1 | Asynchronous pin B |
| quad_mode | input | 1 | 0 = pulse mode on A, 1 = quadrature mode |
| edge_sel | input | 2 | Admitted edges: 0 rising, 1 falling, 2/3 both |
| ceil_load | input | 1 | One-cycle strobe that loads the ceiling |
| ceil_value | input | CNT_W | Ceiling value taken on `ceil_load` |
| count | output | CNT_W | Current count |
| dir_down | output | 1 | 1 when the most recent step was downward |

## Verification
The hardest situations to reach from the ports are the wrap boundaries met under each edge polarity, and a transition in which both pins flip together. The bench loads a small ceiling so that wrap in both directions happens many times within a short sweep. For each mode and edge select, it walks every ordered pair of pin states, including the four pairs in which both pins change. It predicts each step from a phase-difference formulation of the encoder rather than from the per-edge table. A separate load above the build-time maximum confirms the clamp by wrapping downward onto it.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE     = 2'd0,
    EDGE_FALL     = 2'd1,
    EDGE_BOTH     = 2'd2,
    EDGE_BOTH_ALT = 2'd3
  } edge_sel_t;

  typedef struct packed {
    logic up;
    logic dn;
  } step_t;

  // Direction decode for a single admitted edge; the level of the
  // pin that did not move decides the sign.
  function automatic step_t quad_step(
    input logic a_r, input logic a_f,
    input logic b_r, input logic b_f,
    input logic a_lvl, input logic b_lvl);
    step_t s;
    s.up = (a_r & ~b_lvl) | (b_r &  a_lvl) | (a_f &  b_lvl) | (b_f & ~a_lvl);
    s.dn = (a_r &  b_lvl) | (b_r & ~a_lvl) | (a_f & ~b_lvl) | (b_f &  a_lvl);
    return s;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[LAST];
    end
  end

  assign level = chain[LAST];
  assign rise  = chain[LAST] & ~prev;
  assign fall  = ~chain[LAST] & prev;
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
  import qenc_pkg::*;
(
  input  logic      quad_mode,
  input  edge_sel_t edge_sel,
  input  logic      a_lvl,
  input  logic      b_lvl,
  input  logic      a_rise,
  input  logic      a_fall,
  input  logic      b_rise,
  input  logic      b_fall,
  output logic      step_up,
  output logic      step_dn
);
  logic  use_rise, use_fall;
  logic  a_chg, b_chg;
  step_t qs;

  always_comb begin
    use_rise = (edge_sel != EDGE_FALL);
    use_fall = (edge_sel != EDGE_RISE);
    a_chg    = a_rise | a_fall;
    b_chg    = b_rise | b_fall;
    qs       = quad_step(a_rise & use_rise, a_fall & use_fall,
                         b_rise & use_rise, b_fall & use_fall,
                         a_lvl, b_lvl);
    step_up  = 1'b0;
    step_dn  = 1'b0;
    if (!quad_mode) begin
      step_up = (a_rise & use_rise) | (a_fall & use_fall);
    end else if (!(a_chg && b_chg)) begin
      step_up = qs.up;
      step_dn = qs.dn;
    end
  end
endmodule

// File: rtl/qenc_wrap_counter.sv
module qenc_wrap_counter #(
  parameter int               CNT_W    = 16,
  parameter logic [CNT_W-1:0] MAX_CEIL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ceil_load,
  input  logic [CNT_W-1:0] ceil_value,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] ceil_q,
  output logic             dir_down
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_up(
    input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] top);
    return (c >= top) ? ZERO : c + ONE;
  endfunction

  function automatic logic [CNT_W-1:0] next_dn(
    input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] top);
    return (c == ZERO) ? top : c - ONE;
  endfunction

  function automatic logic [CNT_W-1:0] clamp_ceil(input logic [CNT_W-1:0] v);
    return (v > MAX_CEIL) ? MAX_CEIL : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= ZERO;
      ceil_q   <= MAX_CEIL;
      dir_down <= 1'b0;
    end else if (ceil_load) begin
      ceil_q <= clamp_ceil(ceil_value);
      count  <= ZERO;
    end else if (step_up) begin
      count    <= next_up(count, ceil_q);
      dir_down <= 1'b0;
    end else if (step_dn) begin
      count    <= next_dn(count, ceil_q);
      dir_down <= 1'b1;
    end
  end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int               CNT_W       = 16,
  parameter logic [CNT_W-1:0] MAX_CEIL    = '1,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             quad_mode,
  input  logic [1:0]       edge_sel,
  input  logic             ceil_load,
  input  logic [CNT_W-1:0] ceil_value,
  output logic [CNT_W-1:0] count,
  output logic             dir_down
);
  localparam int NCH = 2;

  logic [NCH-1:0]   pin_raw, pin_lvl, pin_rise, pin_fall;
  logic             step_up, step_dn;
  logic [CNT_W-1:0] ceil_q;

  assign pin_raw = {in_b, in_a};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qenc_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_raw[c]),
      .level (pin_lvl[c]),
      .rise  (pin_rise[c]),
      .fall  (pin_fall[c])
    );
  end

  qenc_step_decode i_dec (
    .quad_mode (quad_mode),
    .edge_sel  (edge_sel_t'(edge_sel)),
    .a_lvl     (pin_lvl[0]),
    .b_lvl     (pin_lvl[1]),
    .a_rise    (pin_rise[0]),
    .a_fall    (pin_fall[0]),
    .b_rise    (pin_rise[1]),
    .b_fall    (pin_fall[1]),
    .step_up   (step_up),
    .step_dn   (step_dn)
  );

  qenc_wrap_counter #(.CNT_W(CNT_W), .MAX_CEIL(MAX_CEIL)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ceil_load  (ceil_load),
    .ceil_value (ceil_value),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .count      (count),
    .ceil_q     (ceil_q),
    .dir_down   (dir_down)
  );
endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
  parameter int               CNT_W    = 16,
  parameter logic [CNT_W-1:0] MAX_CEIL = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             quad_mode,
  input logic             ceil_load,
  input logic [1:0]       pin_rise,
  input logic [1:0]       pin_fall,
  input logic             step_up,
  input logic             step_dn,
  input logic [CNT_W-1:0] ceil_q,
  input logic [CNT_W-1:0] count,
  input logic             dir_down
);
  logic a_chg, b_chg;
  assign a_chg = pin_rise[0] | pin_fall[0];
  assign b_chg = pin_rise[1] | pin_fall[1];

  p_pulse_up_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !quad_mode |-> !step_dn);

  p_simult_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_mode && a_chg && b_chg) |-> (!step_up && !step_dn));

  p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ceil_q);

  p_wrap_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !ceil_load && count == ceil_q) |=> (count == '0));

  p_wrap_dn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !ceil_load && count == '0) |=> (count == $past(ceil_q)));

  p_ceil_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ceil_q <= MAX_CEIL);

  p_load_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ceil_load |=> (count == '0));

  p_one_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  p_dir_dn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !ceil_load) |=> dir_down);

  p_dir_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !ceil_load) |=> !dir_down);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn && !ceil_load) |=> ($stable(count) && $stable(dir_down)));
endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W), .MAX_CEIL(MAX_CEIL)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .quad_mode (quad_mode),
  .ceil_load (ceil_load),
  .pin_rise  (pin_rise),
  .pin_fall  (pin_fall),
  .step_up   (step_up),
  .step_dn   (step_dn),
  .ceil_q    (ceil_q),
  .count     (count),
  .dir_down  (dir_down)
);

// File: tb/test_qenc_counter.sv
module test_qenc_counter;
  localparam int           W    = 16;
  localparam logic [W-1:0] MAXC = 16'h0FFF;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         a = 1'b0, b = 1'b0, quad = 1'b0, ld = 1'b0;
  logic [1:0]   esel = 2'd0;
  logic [W-1:0] cv = '0;
  logic [W-1:0] count;
  logic         dirdn;

  int nvec = 0, nbad = 0;
  logic [W-1:0] exp_cnt = '0, exp_ceil = MAXC;
  logic         exp_dir = 1'b0;

  always #2 clk = ~clk;

  qenc_counter #(.CNT_W(W), .MAX_CEIL(MAXC)) i_qenc_counter (
    .clk(clk), .rst_n(rst_n), .in_a(a), .in_b(b), .quad_mode(quad),
    .edge_sel(esel), .ceil_load(ld), .ceil_value(cv),
    .count(count), .dir_down(dirdn));

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] expv);
    nvec++;
    if (got !== expv) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  function automatic int phase(input logic x, input logic y);
    case ({x, y})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  // Apply a new pin state, predict, wait out the pipeline, compare.
  task automatic move(input logic na, input logic nb);
    int    d, s;
    string tag;
    logic  rise_ok, fall_ok, moved_hi;
    d = 0;
    rise_ok = (esel != 2'd1);
    fall_ok = (esel != 2'd0);
    if (!quad) begin
      if (na != a) begin
        tag = "R2";
        if ((na && rise_ok) || (!na && fall_ok)) d = 1;
      end else tag = "R3";
    end else begin
      tag = (esel == 2'd0) ? "R4" : (esel == 2'd1) ? "R5" : "R6";
      if (na != a && nb != b) tag = "R7";
      else begin
        s = (phase(na, nb) - phase(a, b) + 4) % 4;
        moved_hi = (na != a) ? na : nb;
        if ((moved_hi && rise_ok) || (!moved_hi && fall_ok))
          d = (s == 1) ? 1 : (s == 3) ? -1 : 0;
      end
    end
    if (d == 1) begin
      if (exp_cnt == exp_ceil) begin exp_cnt = '0; tag = "R8"; end
      else exp_cnt = exp_cnt + 1'b1;
      exp_dir = 1'b0;
    end else if (d == -1) begin
      if (exp_cnt == '0) begin exp_cnt = exp_ceil; tag = "R9"; end
      else exp_cnt = exp_cnt - 1'b1;
      exp_dir = 1'b1;
    end
    @(negedge clk);
    a = na; b = nb;
    repeat (4) @(negedge clk);
    chk(tag, count, exp_cnt);
    chk("R11", {{(W-1){1'b0}}, dirdn}, {{(W-1){1'b0}}, exp_dir});
  endtask

  task automatic load_ceil(input logic [W-1:0] v);
    @(negedge clk);
    ld = 1'b1; cv = v;
    @(negedge clk);
    ld = 1'b0;
    exp_ceil = (v > MAXC) ? MAXC : v;
    exp_cnt  = '0;
    chk("R10", count, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", count, '0);
    chk("R1", {{(W-1){1'b0}}, dirdn}, '0);

    // R1: default ceiling seen by wrapping down from zero
    quad = 1'b1; esel = 2'd2;
    move(1'b0, 1'b1);
    chk("R1", count, MAXC);
    move(1'b0, 1'b0);

    // R12: latency of a pulse-mode rising edge on A
    quad = 1'b0; esel = 2'd0;
    @(negedge clk); a = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R12", count, exp_cnt);
    @(negedge clk);
    exp_cnt = exp_cnt + 1'b1;
    chk("R12", count, exp_cnt);
    repeat (2) @(negedge clk);

    // R10: clamp an oversize ceiling, then wrap down onto it
    load_ceil(16'hFFFF);
    quad = 1'b1; esel = 2'd2;
    move(1'b0, 1'b0);
    chk("R10", count, MAXC);

    load_ceil(16'd5);

    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 4; e++)
        for (int f = 0; f < 4; f++)
          for (int t = 0; t < 4; t++)
            if (f != t) begin
              @(negedge clk);
              quad = m[0]; esel = e[1:0];
              move(f[1], f[0]);
              move(t[1], t[0]);
            end

    // R6: full forward then reverse cycle in 4x mode
    quad = 1'b1; esel = 2'd3;
    move(1'b0, 1'b0); move(1'b1, 1'b0); move(1'b1, 1'b1); move(1'b0, 1'b1); move(1'b0, 1'b0);
    move(1'b0, 1'b1); move(1'b1, 1'b1); move(1'b1, 1'b0); move(1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule